// File: doc/BRIEF.md
# Floating-point condition code update unit

This unit holds the four condition code bits of a floating-point unit (C0, C1, C2, C3) and rewrites them once for each retired floating-point operation. Each retiring operation presents a class code and a bundle of result sideband signals: compare outcome, unordered flag, zero indication, operand class, sign, partial-remainder quotient bits, reduction-incomplete status, round-up, stack fault and fault direction, and a nibble read from memory. From the class, the unit decides for every bit whether it is loaded from a sideband signal, forced to a constant, taken from memory, or left undefined.

A bit that is undefined for the current class keeps its old value, and the unit reports it through a registered per-bit "defined" mask that changes in the same cycle as the code bits. The operation input is a plain strobe, `op_valid`, with no ready signal. The unit never applies back-pressure and accepts an operation on every cycle where `op_valid` is high. Both outputs are registered, so results appear one clock after the strobe.

Top module: `fpu_cc_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `cc` to 0000 and `cc_defined` to 1111 on the next clock edge.
- R2: When `op_valid` is low, `cc` and `cc_defined` keep their values, whatever the other inputs do.
- R3: Class code 0 (compare/test) sets C0 = `cmp_lt` OR `cmp_unord`, C3 = `cmp_eq` OR `cmp_unord`, C2 = `cmp_unord`, and C1 = `zero_ind`. All four bits are defined.
- R4: Class code 1 (operand examine) sets C3 = `opnd_class[2]`, C2 = `opnd_class[1]`, C0 = `opnd_class[0]`, and C1 = `opnd_sign`. All four bits are defined.
- R5: Class code 2 (partial remainder) sets C0 = `rem_quo[2]`, C3 = `rem_quo[1]`, C1 = `rem_quo[0]`, and C2 = `red_incomplete`. All four bits are defined.
- R6: Class code 3 (trigonometric) sets C2 = `red_incomplete`. It sets C1 = `round_up` only while `red_incomplete` is 0; otherwise C1 is undefined. C0 and C3 are undefined.
- R7: Class code 4 (store/arithmetic/transcendental) sets C1 = `round_up`. C0, C2 and C3 are undefined.
- R8: Class code 5 (sign change, absolute value, exchange, stack adjust, loads) sets C1 = `zero_ind`. C0, C2 and C3 are undefined.
- R9: Class code 6 (environment restore) loads bit i of `cc` from `mem_cc[i]`. All four bits are defined.
- R10: Class code 7 (initialize/save) clears all four bits. All four bits are defined.
- R11: Class code 8 (control load, environment/control/status store, exception clear) and the unassigned codes 9 to 15 leave all four bits undefined.
- R12: For classes 0 to 5, whenever C1 is defined and `stk_fault` is 1, C1 takes `stk_ovf` (1 = overflow, 0 = underflow) in place of its normal source.
- R13: An undefined bit keeps its previous register value. Its `cc_defined` bit reads 0 and a defined bit reads 1, both from the same edge that updates `cc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation retire strobe |
| op_class | input | 4 | Operation class code |
| cmp_lt | input | 1 | Compare: first operand less than second |
| cmp_eq | input | 1 | Compare: operands equal |
| cmp_unord | input | 1 | Compare: operands unordered |
| zero_ind | input | 1 | Zero indication for C1 |
| opnd_class | input | 3 | Examine: operand class code |
| opnd_sign | input | 1 | Examine: operand sign |
| rem_quo | input | 3 | Remainder quotient bits {Q2,Q1,Q0} |
| red_incomplete | input | 1 | Argument reduction not finished |
| round_up | input | 1 | Result was rounded up |
| stk_fault | input | 1 | Stack overflow/underflow occurred |
| stk_ovf | input | 1 | Fault direction: 1 overflow, 0 underflow |
| mem_cc | input | 4 | Condition code nibble from memory |
| cc | output | 4 | Condition code register, bit i = Ci |
| cc_defined | output | 4 | Per-bit defined mask of the last update |

## Verification
A stack fault can arrive in the same cycle as the normal C1 source of every class. For trigonometric operations, it can also coincide with an incomplete reduction that makes C1 undefined. The bench sweeps all sixteen class codes against hashed sideband vectors in which `stk_fault`, `stk_ovf` and `red_incomplete` vary independently. Before each operation it preloads the register through a restore with a known pattern. It then compares the full code register and the mask against values worked out from the requirements, so a kept bit, a fault-overridden C1 and a suppressed trigonometric C1 are each judged exactly.

// File: rtl/fpu_cc_pkg.sv
package fpu_cc_pkg;
  localparam int CC_W  = 4;
  localparam int CLS_W = 4;

  localparam logic [CLS_W-1:0] CLS_CMP     = 4'd0;
  localparam logic [CLS_W-1:0] CLS_EXAM    = 4'd1;
  localparam logic [CLS_W-1:0] CLS_PREM    = 4'd2;
  localparam logic [CLS_W-1:0] CLS_TRIG    = 4'd3;
  localparam logic [CLS_W-1:0] CLS_ROUND   = 4'd4;
  localparam logic [CLS_W-1:0] CLS_MOVE    = 4'd5;
  localparam logic [CLS_W-1:0] CLS_RESTORE = 4'd6;
  localparam logic [CLS_W-1:0] CLS_INIT    = 4'd7;

  typedef struct packed {
    logic       lt;
    logic       eq;
    logic       unord;
    logic       zero;
    logic [2:0] ocls;
    logic       sign;
    logic [2:0] quo;
    logic       inc;
    logic       rup;
    logic       fault;
    logic       ovf;
  } side_t;
endpackage

// File: rtl/fpu_cc_c1_sel.sv
module fpu_cc_c1_sel (
  input  logic norm_val,
  input  logic fault,
  input  logic ovf,
  output logic c1_out
);
  // stack fault direction overrides the class's normal C1 source
  always_comb c1_out = fault ? ovf : norm_val;
endmodule

// File: rtl/fpu_cc_route.sv
module fpu_cc_route
  import fpu_cc_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  input  side_t            side,
  input  logic [CC_W-1:0]  mem,
  output logic [CC_W-1:0]  nv,
  output logic [CC_W-1:0]  def
);
  logic c1_norm;
  logic c1_use;
  logic c1_fin;

  // choose C1's normal source and whether C1 is written at all
  always_comb begin
    c1_norm = 1'b0;
    c1_use  = 1'b0;
    case (cls)
      CLS_CMP:   begin c1_norm = side.zero;   c1_use = 1'b1; end
      CLS_EXAM:  begin c1_norm = side.sign;   c1_use = 1'b1; end
      CLS_PREM:  begin c1_norm = side.quo[0]; c1_use = 1'b1; end
      CLS_TRIG:  begin c1_norm = side.rup;    c1_use = ~side.inc; end
      CLS_ROUND: begin c1_norm = side.rup;    c1_use = 1'b1; end
      CLS_MOVE:  begin c1_norm = side.zero;   c1_use = 1'b1; end
      default:   begin c1_norm = 1'b0;        c1_use = 1'b0; end
    endcase
  end

  fpu_cc_c1_sel u_c1 (
    .norm_val (c1_norm),
    .fault    (side.fault),
    .ovf      (side.ovf),
    .c1_out   (c1_fin)
  );

  always_comb begin
    nv  = '0;
    def = '0;
    case (cls)
      CLS_CMP: begin
        nv[0] = side.lt | side.unord;
        nv[3] = side.eq | side.unord;
        nv[2] = side.unord;
        def   = '1;
      end
      CLS_EXAM: begin
        nv[3] = side.ocls[2];
        nv[2] = side.ocls[1];
        nv[0] = side.ocls[0];
        def   = '1;
      end
      CLS_PREM: begin
        nv[0] = side.quo[2];
        nv[3] = side.quo[1];
        nv[2] = side.inc;
        def   = '1;
      end
      CLS_TRIG: begin
        nv[2]  = side.inc;
        def[2] = 1'b1;
      end
      CLS_RESTORE: begin
        nv  = mem;
        def = '1;
      end
      CLS_INIT: begin
        nv  = '0;
        def = '1;
      end
      default: ;
    endcase
    if (c1_use) begin
      nv[1]  = c1_fin;
      def[1] = 1'b1;
    end
  end
endmodule

// File: rtl/fpu_cc_reg.sv
module fpu_cc_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] nv,
  input  logic [W-1:0] def,
  output logic [W-1:0] q,
  output logic [W-1:0] q_def
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        q[i]     <= 1'b0;
        q_def[i] <= 1'b1;
      end else if (upd) begin
        q_def[i] <= def[i];
        if (def[i]) q[i] <= nv[i];
      end
    end
  end
endmodule

// File: rtl/fpu_cc_unit.sv
module fpu_cc_unit
  import fpu_cc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [CLS_W-1:0] op_class,
  input  logic             cmp_lt,
  input  logic             cmp_eq,
  input  logic             cmp_unord,
  input  logic             zero_ind,
  input  logic [2:0]       opnd_class,
  input  logic             opnd_sign,
  input  logic [2:0]       rem_quo,
  input  logic             red_incomplete,
  input  logic             round_up,
  input  logic             stk_fault,
  input  logic             stk_ovf,
  input  logic [CC_W-1:0]  mem_cc,
  output logic [CC_W-1:0]  cc,
  output logic [CC_W-1:0]  cc_defined
);
  side_t           side;
  logic [CC_W-1:0] nxt;
  logic [CC_W-1:0] nxt_def;

  always_comb begin
    side.lt    = cmp_lt;
    side.eq    = cmp_eq;
    side.unord = cmp_unord;
    side.zero  = zero_ind;
    side.ocls  = opnd_class;
    side.sign  = opnd_sign;
    side.quo   = rem_quo;
    side.inc   = red_incomplete;
    side.rup   = round_up;
    side.fault = stk_fault;
    side.ovf   = stk_ovf;
  end

  fpu_cc_route u_route (
    .cls  (op_class),
    .side (side),
    .mem  (mem_cc),
    .nv   (nxt),
    .def  (nxt_def)
  );

  fpu_cc_reg #(.W(CC_W)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .upd   (op_valid),
    .nv    (nxt),
    .def   (nxt_def),
    .q     (cc),
    .q_def (cc_defined)
  );
endmodule

// File: rtl/fpu_cc_chk.sv
module fpu_cc_chk (
  input logic       clk,
  input logic       rst,
  input logic       op_valid,
  input logic [3:0] op_class,
  input logic [2:0] rem_quo,
  input logic       red_incomplete,
  input logic       stk_fault,
  input logic       stk_ovf,
  input logic [3:0] mem_cc,
  input logic [3:0] cc,
  input logic [3:0] cc_defined
);
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (cc == 4'b0000 && cc_defined == 4'b1111));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(cc) && $stable(cc_defined)));

  a_r5_remainder: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == 4'd2 && !stk_fault) |=>
      (cc == {$past(rem_quo[1]), $past(red_incomplete), $past(rem_quo[0]), $past(rem_quo[2])}));

  a_r9_restore: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == 4'd6) |=> (cc == $past(mem_cc)));

  a_r10_init: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == 4'd7) |=> (cc == 4'b0000 && cc_defined == 4'b1111));

  a_r11_all_undef: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class >= 4'd8) |=> ($stable(cc) && cc_defined == 4'b0000));

  a_r12_fault_c1: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_class == 4'd4 || op_class == 4'd5) && stk_fault) |=>
      (cc[1] == $past(stk_ovf)));

  a_r13_trig_keep: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == 4'd3 && red_incomplete) |=>
      (cc_defined == 4'b0100 && cc[1] == $past(cc[1])));
endmodule

bind fpu_cc_unit fpu_cc_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .op_valid       (op_valid),
  .op_class       (op_class),
  .rem_quo        (rem_quo),
  .red_incomplete (red_incomplete),
  .stk_fault      (stk_fault),
  .stk_ovf        (stk_ovf),
  .mem_cc         (mem_cc),
  .cc             (cc),
  .cc_defined     (cc_defined)
);

// File: tb/sim_fpu_cc_unit.sv
`timescale 1ns/1ps
module sim_fpu_cc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_class = '0;
  logic [14:0] sb = '0;
  logic [3:0]  mem_cc = '0;
  logic [3:0]  cc;
  logic [3:0]  cc_defined;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  fpu_cc_unit u0 (
    .clk            (clk),
    .rst            (rst),
    .op_valid       (op_valid),
    .op_class       (op_class),
    .cmp_lt         (sb[0]),
    .cmp_eq         (sb[1]),
    .cmp_unord      (sb[2]),
    .zero_ind       (sb[3]),
    .opnd_class     (sb[6:4]),
    .opnd_sign      (sb[7]),
    .rem_quo        (sb[10:8]),
    .red_incomplete (sb[11]),
    .round_up       (sb[12]),
    .stk_fault      (sb[13]),
    .stk_ovf        (sb[14]),
    .mem_cc         (mem_cc),
    .cc             (cc),
    .cc_defined     (cc_defined)
  );

  // expected {defined mask, code} from the requirements
  function automatic logic [7:0] model(input logic [3:0] c, input logic [14:0] s,
                                       input logic [3:0] m, input logic [3:0] prev);
    logic [3:0] v;
    logic [3:0] d;
    logic flt, ovf;
    flt = s[13];
    ovf = s[14];
    v = prev;
    d = 4'b0000;
    case (c)
      4'd0: begin v[0] = s[0] | s[2]; v[3] = s[1] | s[2]; v[2] = s[2];
                  v[1] = flt ? ovf : s[3]; d = 4'b1111; end
      4'd1: begin v[3] = s[6]; v[2] = s[5]; v[0] = s[4];
                  v[1] = flt ? ovf : s[7]; d = 4'b1111; end
      4'd2: begin v[0] = s[10]; v[3] = s[9]; v[2] = s[11];
                  v[1] = flt ? ovf : s[8]; d = 4'b1111; end
      4'd3: begin v[2] = s[11]; d = 4'b0100;
                  if (!s[11]) begin v[1] = flt ? ovf : s[12]; d = 4'b0110; end end
      4'd4: begin v[1] = flt ? ovf : s[12]; d = 4'b0010; end
      4'd5: begin v[1] = flt ? ovf : s[3];  d = 4'b0010; end
      4'd6: begin v = m; d = 4'b1111; end
      4'd7: begin v = 4'b0000; d = 4'b1111; end
      default: d = 4'b0000;
    endcase
    return {d, v};
  endfunction

  function automatic string tag(input logic [3:0] c, input logic [14:0] s);
    if (c <= 4'd5 && s[13] && !(c == 4'd3 && s[11])) return "R12";
    case (c)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4: return "R7";
      4'd5: return "R8";
      4'd6: return "R9";
      4'd7: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string r, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", r, got, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] c, input logic [14:0] s, input logic [3:0] m);
    @(negedge clk);
    op_class = c;
    sb       = s;
    mem_cc   = m;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  logic [14:0] vec;
  logic [3:0]  pre;
  logic [3:0]  mv;
  logic [7:0]  exp;
  logic [3:0]  hold_cc;
  logic [3:0]  hold_def;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", cc, 4'b0000);
    chk("R1", cc_defined, 4'b1111);

    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 512; k++) begin
        vec = 15'((k * 16'h4F1B) ^ (k << 7) ^ (c * 16'h0123));
        pre = 4'(k ^ (k >> 4) ^ c);
        mv  = 4'((k >> 2) ^ 9);
        do_op(4'd6, 15'h0, pre);
        chk("R9", cc, pre);
        exp = model(4'(c), vec, mv, pre);
        do_op(4'(c), vec, mv);
        chk(tag(4'(c), vec), cc, exp[3:0]);
        chk("R13", cc_defined, exp[7:4]);
      end
    end

    // R2: inputs toggle while the strobe stays low
    do_op(4'd6, 15'h0, 4'b1011);
    hold_cc  = cc;
    hold_def = cc_defined;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      op_class = 4'(i);
      sb       = 15'(16'h7FFF ^ (i * 16'h1357));
      mem_cc   = 4'(~i);
      chk("R2", cc, hold_cc);
      chk("R2", cc_defined, hold_def);
    end

    // R1 mid-run, after an undefined-only update changed the mask
    do_op(4'd6, 15'h0, 4'b1010);
    do_op(4'd8, 15'h0, 4'b0000);
    chk("R13", cc_defined, 4'b0000);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", cc, 4'b0000);
    chk("R1", cc_defined, 4'b1111);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule